// File: doc/BRIEF.md
# Pipelined Complex Mixer

This block multiplies a complex data sample (a + jb) by a complex oscillator sample (c + jd), where c carries the cosine and d the sine of a local oscillator. It returns the real part a·c − b·d and the imaginary part a·d + b·c. Every operand and result is two's complement.

The datapath has three register stages. The first stage forms the four partial products in parallel at full precision. The second stage forms the difference and the sum one bit wider than a product. The third stage cuts the wide result down to the output width and registers it. A valid flag travels through the same three stages, so a mixer, a modulator or a down-converter can count on a fixed three-cycle delay when it budgets its latency.

Truncation is defined as follows. The top bit of the wide sum is dropped, and the next OW bits are kept. This equals a floor division by 2^(2·DW−OW), as long as no operand takes the most negative code.

Top module: `cmix_mixer`

## Requirements
- R1: The real output equals bits [2·DW−1 : 2·DW−OW] of the exact value a·c − b·d. This is floor((a·c − b·d) / 2^(2·DW−OW)) taken modulo 2^OW.
- R2: The imaginary output equals bits [2·DW−1 : 2·DW−OW] of the exact value a·d + b·c, with the same floor rule as R1.
- R3: Operands captured on the clock edge at which in_vld is high produce their result on the outputs after the third following rising edge.
- R4: out_vld is high for exactly one cycle per accepted sample, three cycles after that sample's in_vld. It is low otherwise.
- R5: In a cycle where out_vld is low, re_o and im_o keep the last result that was delivered, or zero if none has been delivered since reset.
- R6: While rst is high, out_vld, re_o and im_o are zero. The reset acts at once, without waiting for a clock edge. It also discards every sample still in flight.
- R7: Operands never take the most negative code (−2^(DW−1)). Under that rule, the full-width sum and difference fit in 2·DW bits, so the dropped top bit is always a copy of the sign.
- R8: Samples may arrive on every cycle. Results then leave one per cycle, in arrival order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Asynchronous reset, active high |
| in_vld | input | 1 | The operands on a_i..d_i are valid this cycle |
| a_i | input | DW | Real part of the data sample, two's complement |
| b_i | input | DW | Imaginary part of the data sample, two's complement |
| c_i | input | DW | Oscillator cosine sample, two's complement |
| d_i | input | DW | Oscillator sine sample, two's complement |
| out_vld | output | 1 | re_o and im_o carry a new result |
| re_o | output | OW | Truncated real result |
| im_o | output | OW | Truncated imaginary result |

## Verification
The bench streams every permitted operand combination of a 4-bit configuration. A new sample is often accepted in the same cycle that an older result leaves the pipeline. Bubbles are inserted at a fixed rhythm, so acceptance, emission and output hold overlap in every arrangement. Every emitted value is compared with arithmetic done in the bench, and so is its arrival cycle. The bench also raises reset between clock edges while the pipeline is full. It judges that case by requiring zero outputs before the next edge, and by requiring that none of the discarded samples ever emerges.

// File: rtl/cmix_pkg.sv
package cmix_pkg;

  // Width of one partial product for DW-bit signed operands.
  function automatic int prod_width(input int dw);
    return 2 * dw;
  endfunction

  // Width of the full-precision sum/difference of two products.
  function automatic int sum_width(input int dw);
    return 2 * dw + 1;
  endfunction

  // Number of register stages from operand capture to output.
  localparam int CMIX_LATENCY = 3;

endpackage

// File: rtl/cmix_prod_stage.sv
module cmix_prod_stage #(
  parameter int DW = 8,
  parameter int PW = 2 * DW
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_vld,
  input  logic signed [DW-1:0] a_i,
  input  logic signed [DW-1:0] b_i,
  input  logic signed [DW-1:0] c_i,
  input  logic signed [DW-1:0] d_i,
  output logic                 vld_q,
  output logic signed [PW-1:0] p_ac_q,
  output logic signed [PW-1:0] p_bd_q,
  output logic signed [PW-1:0] p_ad_q,
  output logic signed [PW-1:0] p_bc_q
);

  localparam int NPROD = 4;
  localparam logic signed [DW-1:0] MOST_NEG = {1'b1, {(DW-1){1'b0}}};

  logic signed [DW-1:0] op_x [NPROD];
  logic signed [DW-1:0] op_y [NPROD];
  logic signed [PW-1:0] prod_d [NPROD];
  logic signed [PW-1:0] prod_q [NPROD];

  // Product order: 0 = a*c, 1 = b*d, 2 = a*d, 3 = b*c
  always_comb begin
    op_x[0] = a_i; op_y[0] = c_i;
    op_x[1] = b_i; op_y[1] = d_i;
    op_x[2] = a_i; op_y[2] = d_i;
    op_x[3] = b_i; op_y[3] = c_i;
  end

  for (genvar gi = 0; gi < NPROD; gi++) begin : g_mult
    logic signed [PW-1:0] ext_x;
    logic signed [PW-1:0] ext_y;

    always_comb begin
      ext_x      = PW'(op_x[gi]);
      ext_y      = PW'(op_y[gi]);
      prod_d[gi] = ext_x * ext_y;
    end

    always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
        prod_q[gi] <= '0;
      end else if (in_vld) begin
        prod_q[gi] <= prod_d[gi];
      end
    end
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      vld_q <= 1'b0;
    end else begin
      vld_q <= in_vld;
    end
  end

  assign p_ac_q = prod_q[0];
  assign p_bd_q = prod_q[1];
  assign p_ad_q = prod_q[2];
  assign p_bc_q = prod_q[3];

  AST_OPERAND_RANGE: assert property (@(posedge clk) disable iff (rst)
    in_vld |-> (a_i != MOST_NEG && b_i != MOST_NEG && c_i != MOST_NEG && d_i != MOST_NEG)); // R7
  AST_PROD_VLD_SET: assert property (@(posedge clk) disable iff (rst)
    in_vld |=> vld_q); // R4
  AST_PROD_VLD_CLR: assert property (@(posedge clk) disable iff (rst)
    !in_vld |=> !vld_q); // R4

endmodule

// File: rtl/cmix_sum_stage.sv
module cmix_sum_stage #(
  parameter int PW = 16,
  parameter int SW = PW + 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_vld,
  input  logic signed [PW-1:0] p_ac,
  input  logic signed [PW-1:0] p_bd,
  input  logic signed [PW-1:0] p_ad,
  input  logic signed [PW-1:0] p_bc,
  output logic                 vld_q,
  output logic signed [SW-1:0] re_q,
  output logic signed [SW-1:0] im_q
);

  logic signed [SW-1:0] ac_x, bd_x, ad_x, bc_x;
  logic signed [SW-1:0] re_d, im_d;

  always_comb begin
    ac_x = SW'(p_ac);
    bd_x = SW'(p_bd);
    ad_x = SW'(p_ad);
    bc_x = SW'(p_bc);
    re_d = ac_x - bd_x;
    im_d = ad_x + bc_x;
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      re_q <= '0;
      im_q <= '0;
    end else if (in_vld) begin
      re_q <= re_d;
      im_q <= im_d;
    end
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      vld_q <= 1'b0;
    end else begin
      vld_q <= in_vld;
    end
  end

  AST_SUM_HEADROOM: assert property (@(posedge clk) disable iff (rst)
    vld_q |-> (re_q[SW-1] == re_q[SW-2] && im_q[SW-1] == im_q[SW-2])); // R7
  AST_SUM_VLD_SET: assert property (@(posedge clk) disable iff (rst)
    in_vld |=> vld_q); // R4

endmodule

// File: rtl/cmix_out_stage.sv
module cmix_out_stage #(
  parameter int SW = 17,
  parameter int OW = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_vld,
  input  logic signed [SW-1:0] re_sum,
  input  logic signed [SW-1:0] im_sum,
  output logic                 vld_q,
  output logic        [OW-1:0] re_q,
  output logic        [OW-1:0] im_q
);

  // Keep the OW bits just below the redundant top bit.
  localparam int TOP = SW - 2;

  logic [OW-1:0] re_d, im_d;

  always_comb begin
    re_d = re_sum[TOP -: OW];
    im_d = im_sum[TOP -: OW];
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      re_q <= '0;
      im_q <= '0;
    end else if (in_vld) begin
      re_q <= re_d;
      im_q <= im_d;
    end
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      vld_q <= 1'b0;
    end else begin
      vld_q <= in_vld;
    end
  end

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !in_vld |=> ($stable(re_q) && $stable(im_q))); // R5
  AST_OUT_VLD_CLR: assert property (@(posedge clk) disable iff (rst)
    !in_vld |=> !vld_q); // R4

endmodule

// File: rtl/cmix_mixer.sv
module cmix_mixer
  import cmix_pkg::*;
#(
  parameter int DW = 8,
  parameter int OW = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_vld,
  input  logic signed [DW-1:0] a_i,
  input  logic signed [DW-1:0] b_i,
  input  logic signed [DW-1:0] c_i,
  input  logic signed [DW-1:0] d_i,
  output logic                 out_vld,
  output logic        [OW-1:0] re_o,
  output logic        [OW-1:0] im_o
);

  localparam int PW = prod_width(DW);
  localparam int SW = sum_width(DW);

  logic                 s1_vld;
  logic signed [PW-1:0] s1_ac, s1_bd, s1_ad, s1_bc;
  logic                 s2_vld;
  logic signed [SW-1:0] s2_re, s2_im;

  cmix_prod_stage #(.DW(DW), .PW(PW)) u_prod (
    .clk    (clk),
    .rst    (rst),
    .in_vld (in_vld),
    .a_i    (a_i),
    .b_i    (b_i),
    .c_i    (c_i),
    .d_i    (d_i),
    .vld_q  (s1_vld),
    .p_ac_q (s1_ac),
    .p_bd_q (s1_bd),
    .p_ad_q (s1_ad),
    .p_bc_q (s1_bc)
  );

  cmix_sum_stage #(.PW(PW), .SW(SW)) u_sum (
    .clk    (clk),
    .rst    (rst),
    .in_vld (s1_vld),
    .p_ac   (s1_ac),
    .p_bd   (s1_bd),
    .p_ad   (s1_ad),
    .p_bc   (s1_bc),
    .vld_q  (s2_vld),
    .re_q   (s2_re),
    .im_q   (s2_im)
  );

  cmix_out_stage #(.SW(SW), .OW(OW)) u_out (
    .clk    (clk),
    .rst    (rst),
    .in_vld (s2_vld),
    .re_sum (s2_re),
    .im_sum (s2_im),
    .vld_q  (out_vld),
    .re_q   (re_o),
    .im_q   (im_o)
  );

  AST_RST_CLEAR: assert property (@(posedge clk)
    (rst && $past(rst)) |-> (!out_vld && re_o == '0 && im_o == '0)); // R6
  AST_STREAM_ORDER: assert property (@(posedge clk) disable iff (rst)
    (s1_vld && s2_vld) |=> (s2_vld && out_vld)); // R8

endmodule

// File: tb/cmix_mixer_tb_top.sv
`timescale 1ns/100ps
module cmix_mixer_tb_top;

  localparam int DW    = 4;
  localparam int OW    = 4;
  localparam int SHIFT = 2 * DW - OW;
  localparam int VMAX  = (1 << (DW - 1)) - 1;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic                 rst;
  logic                 in_vld;
  logic signed [DW-1:0] a_i, b_i, c_i, d_i;
  logic                 out_vld;
  logic        [OW-1:0] re_o, im_o;

  cmix_mixer #(.DW(DW), .OW(OW)) dut_i (
    .clk(clk), .rst(rst), .in_vld(in_vld),
    .a_i(a_i), .b_i(b_i), .c_i(c_i), .d_i(d_i),
    .out_vld(out_vld), .re_o(re_o), .im_o(im_o)
  );

  int n_cmp = 0;
  int n_bad = 0;
  int cyc   = 0;
  int sent  = 0;
  logic [OW-1:0] q_re [$];
  logic [OW-1:0] q_im [$];
  int            q_t  [$];
  logic [OW-1:0] last_re = '0;
  logic [OW-1:0] last_im = '0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s cycle %0d: actual=%0h expected=%0h", req, cyc, act, exp);
    end
  endtask

  function automatic logic [OW-1:0] trunc(input int v);
    int s;
    s = v >>> SHIFT;
    return s[OW-1:0];
  endfunction

  // One cycle: observe at the falling edge, then drive the next operands.
  task automatic step(input bit v, input int a, input int b, input int c, input int d);
    bit exp_v;
    @(negedge clk);
    cyc++;
    exp_v = (q_t.size() > 0) && (q_t[0] == cyc - 3);
    chk("R4 out_vld", {31'd0, out_vld}, {31'd0, exp_v});
    if (out_vld && q_t.size() > 0) begin
      chk("R3 latency", cyc - q_t[0], 3);
      chk("R1 real", {28'd0, re_o}, {28'd0, q_re[0]});
      chk("R2 imag", {28'd0, im_o}, {28'd0, q_im[0]});
      void'(q_re.pop_front());
      void'(q_im.pop_front());
      void'(q_t.pop_front());
      last_re = re_o;
      last_im = im_o;
    end else if (!out_vld) begin
      chk("R5 hold real", {28'd0, re_o}, {28'd0, last_re});
      chk("R5 hold imag", {28'd0, im_o}, {28'd0, last_im});
    end
    in_vld = v;
    a_i = DW'(a); b_i = DW'(b); c_i = DW'(c); d_i = DW'(d);
    if (v) begin
      q_re.push_back(trunc(a * c - b * d));
      q_im.push_back(trunc(a * d + b * c));
      q_t.push_back(cyc);
      sent++;
    end
  endtask

  task automatic check_reset_outputs(input string tag);
    chk({"R6 vld ", tag}, {31'd0, out_vld}, 32'd0);
    chk({"R6 re ", tag},  {28'd0, re_o}, 32'd0);
    chk({"R6 im ", tag},  {28'd0, im_o}, 32'd0);
  endtask

  task automatic apply_reset();
    @(negedge clk);
    #1 rst = 1'b1;
    in_vld = 1'b0;
    #0.5 check_reset_outputs("async");
    @(negedge clk);
    check_reset_outputs("held");
    rst = 1'b0;
    q_re.delete(); q_im.delete(); q_t.delete();
    last_re = '0; last_im = '0;
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(190000 * 4);
    n_bad++;
    $display("FAIL watchdog: run did not end, actual=hung expected=done");
    finish_run();
  end

  initial begin
    rst = 1'b1; in_vld = 1'b0;
    a_i = '0; b_i = '0; c_i = '0; d_i = '0;
    repeat (3) @(negedge clk);
    check_reset_outputs("initial");
    rst = 1'b0;

    // R8: back-to-back stream of corner values
    step(1,  VMAX,  VMAX,  VMAX,  VMAX);
    step(1, -VMAX, -VMAX,  VMAX, -VMAX);
    step(1,  VMAX, -VMAX, -VMAX,  VMAX);
    step(1,  0,     0,     0,     0);
    step(1,  1,    -1,     1,     1);

    // R6: reset while samples are in flight; none of them may emerge
    apply_reset();
    step(0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0);

    // R1 R2 R3 R4 R5 R8: sweep of all permitted operands with periodic bubbles
    begin
      int idx;
      idx = 0;
      for (int a = -VMAX; a <= VMAX; a++)
        for (int b = -VMAX; b <= VMAX; b++)
          for (int c = -VMAX; c <= VMAX; c++)
            for (int d = -VMAX; d <= VMAX; d++) begin
              if (idx % 7 == 3) step(0, 0, 0, 0, 0);
              if (idx % 101 == 50) begin
                step(0, 0, 0, 0, 0);
                step(0, 0, 0, 0, 0);
                step(0, 0, 0, 0, 0);
              end
              step(1, a, b, c, d);
              idx++;
            end
    end

    // Drain and observe the hold after the final result
    for (int k = 0; k < 6; k++) step(0, 0, 0, 0, 0);
    chk("R8 all results delivered", q_t.size(), 0);

    // R6: a late reset clears the delivered result as well
    apply_reset();
    step(0, 0, 0, 0, 0);
    finish_run();
  end

endmodule